// File: doc/BRIEF.md
# Bit Scan and Count Unit

This unit takes one data word per cycle together with a function code and an operand-width code, and returns a single count-style result. It can locate the lowest or highest set bit, count zeros from the top or from the bottom of the operand, or count the ones. A zero flag comes back with every result and reports whether the operand, after narrowing to the chosen width, has no bits set.

The operand width is chosen per request: 16, 32 or 64 bits. A narrower width looks only at the low bits of the data input. The work is split over two register stages. Stage one narrows the operand, finds the lowest and highest set positions and adds up the ones. Stage two picks the requested answer and applies the rules for a zero operand.

The two kinds of function treat a zero operand differently. The scan functions raise the zero flag and leave the previous result on the output. The zero-count functions return the operand width.

Top module: `bsc_unit`

## Requirements
- R1: Function code 0 returns the index of the lowest set bit of the narrowed operand, counted from 0 at bit 0 (0x18 gives 3).
- R2: Function code 1 returns the index of the highest set bit of the narrowed operand (0x18 gives 4).
- R3: Function code 2 returns the number of zero bits above the highest set bit, counted down from the top bit of the selected width, not from bit 63 (0xA0 at 32 bits gives 24).
- R4: Function code 3 returns the number of zero bits below the lowest set bit.
- R5: Function codes 4 to 7 return the number of one bits in the narrowed operand (0xB5 gives 5).
- R6: Width code 0 selects 16 bits, code 1 selects 32 bits, and codes 2 and 3 select 64 bits. Data bits above the selected width have no effect on the result or on the flag.
- R7: For every function, out_zero is 1 exactly when the narrowed operand is zero.
- R8: A scan function (code 0 or 1) on a zero operand leaves out_result equal to its previous value. out_result changes only on valid requests.
- R9: Function codes 2 and 3 on a zero operand return the selected width (16, 32 or 64).
- R10: out_valid equals in_valid delayed by exactly two clock cycles, and back-to-back requests produce back-to-back results.
- R11: While rst_n is low at a clock edge, out_valid, out_result and out_zero are cleared to 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Synchronous active-low reset |
| in_valid | input | 1 | Request present this cycle |
| in_data | input | 64 | Operand; only the low bits of the selected width are used |
| in_func | input | 3 | Function code (R1 to R5) |
| in_width | input | 2 | Operand width code (R6) |
| out_valid | output | 1 | Result present, two cycles after the request |
| out_result | output | 7 | Index or count |
| out_zero | output | 1 | Narrowed operand was zero |

## Verification
The assertions assume that in_valid is held low while rst_n is low, and that in_func and in_width matter only when in_valid is high. The checker therefore relates each result to the request that entered two cycles earlier, and it arms only after two cycles out of reset. The stimulus drives in_valid low throughout reset. The random traffic mixes idle and valid cycles and draws operands that are often zero, single-bit or zero within the narrowed width. This exercises both zero conventions and the masking of the upper bits.

// File: rtl/bsc_pkg.sv
// Shared codes for the bit scan and count unit.
// Assumes: function and width encodings below are fixed interface values.
package bsc_pkg;
    typedef enum logic [2:0] {
        FN_LOW_IDX  = 3'd0,
        FN_HIGH_IDX = 3'd1,
        FN_LEAD_Z   = 3'd2,
        FN_TRAIL_Z  = 3'd3,
        FN_ONES     = 3'd4
    } bsc_func_e;

    typedef enum logic [1:0] {
        WSEL_16 = 2'd0,
        WSEL_32 = 2'd1,
        WSEL_64 = 2'd2
    } bsc_wsel_e;

    // True for the two scan functions, which hold the result on zero input.
    function automatic logic is_scan(input logic [2:0] f);
        return (f == FN_LOW_IDX) || (f == FN_HIGH_IDX);
    endfunction
endpackage

// File: rtl/bsc_prio_enc.sv
// Priority encoder: returns the index of the lowest (FROM_TOP=0) or highest
// (FROM_TOP=1) set bit of the word, plus a found flag.
// Assumes: idx is don't-care (0) when found is low.
module bsc_prio_enc #(
    parameter int W        = 64,
    parameter bit FROM_TOP = 1'b0,
    localparam int IW      = $clog2(W)
) (
    input  logic [W-1:0]  data,
    output logic [IW-1:0] idx,
    output logic          found
);
    generate
        if (FROM_TOP) begin : g_top
            // Scan upward so the highest set bit is written last.
            always_comb begin
                idx = '0;
                for (int i = 0; i < W; i++) begin
                    if (data[i]) idx = IW'(i);
                end
            end
        end else begin : g_bot
            // Scan downward so the lowest set bit is written last.
            always_comb begin
                idx = '0;
                for (int i = W - 1; i >= 0; i--) begin
                    if (data[i]) idx = IW'(i);
                end
            end
        end
    endgenerate

    assign found = |data;
endmodule

// File: rtl/bsc_popcnt.sv
// Ones counter built as two levels: per-chunk counts, then a sum of chunks.
// Assumes: W is a multiple of CHUNK_W.
module bsc_popcnt #(
    parameter int W       = 64,
    parameter int CHUNK_W = 8,
    localparam int NCH    = W / CHUNK_W,
    localparam int CW     = $clog2(CHUNK_W) + 1,
    localparam int OW     = $clog2(W) + 1
) (
    input  logic [W-1:0]  data,
    output logic [OW-1:0] count
);
    logic [CW-1:0] chunk_cnt [NCH];

    generate
        for (genvar c = 0; c < NCH; c++) begin : g_chunk
            // Count the ones of one chunk.
            always_comb begin
                chunk_cnt[c] = '0;
                for (int b = 0; b < CHUNK_W; b++) begin
                    chunk_cnt[c] = chunk_cnt[c] + CW'(data[c*CHUNK_W + b]);
                end
            end
        end
    endgenerate

    // Add the chunk counts together.
    always_comb begin
        count = '0;
        for (int c = 0; c < NCH; c++) begin
            count = count + OW'(chunk_cnt[c]);
        end
    end
endmodule

// File: rtl/bsc_unit.sv
// Two-stage bit scan and count unit.
// Stage 1 narrows the operand and finds both ends and the ones count.
// Stage 2 selects the function and applies the zero-operand rules.
// Assumes: in_valid low during reset; DATA_W divisible by 4 and by CHUNK_W.
module bsc_unit #(
    parameter int DATA_W  = 64,
    parameter int CHUNK_W = 8,
    localparam int IW     = $clog2(DATA_W),
    localparam int RW     = IW + 1,
    localparam int W_Q    = DATA_W / 4,
    localparam int W_H    = DATA_W / 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              in_valid,
    input  logic [DATA_W-1:0] in_data,
    input  logic [2:0]        in_func,
    input  logic [1:0]        in_width,
    output logic              out_valid,
    output logic [RW-1:0]     out_result,
    output logic              out_zero
);
    import bsc_pkg::*;

    logic [DATA_W-1:0] narrowed;
    logic [IW-1:0]     lo_c, hi_c;
    logic              any_c, any_hi_unused;
    logic [RW-1:0]     ones_c;

    // Narrow the operand to the selected width.
    always_comb begin
        unique case (in_width)
            WSEL_16: narrowed = {{(DATA_W-W_Q){1'b0}}, in_data[W_Q-1:0]};
            WSEL_32: narrowed = {{(DATA_W-W_H){1'b0}}, in_data[W_H-1:0]};
            default: narrowed = in_data;
        endcase
    end

    bsc_prio_enc #(.W(DATA_W), .FROM_TOP(1'b0)) u_lo (
        .data(narrowed), .idx(lo_c), .found(any_c));
    bsc_prio_enc #(.W(DATA_W), .FROM_TOP(1'b1)) u_hi (
        .data(narrowed), .idx(hi_c), .found(any_hi_unused));
    bsc_popcnt #(.W(DATA_W), .CHUNK_W(CHUNK_W)) u_ones (
        .data(narrowed), .count(ones_c));

    logic          s1_valid, s1_any;
    logic [2:0]    s1_func;
    logic [1:0]    s1_wsel;
    logic [IW-1:0] s1_lo, s1_hi;
    logic [RW-1:0] s1_ones;

    // Stage 1 register: capture the partial results.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            s1_valid <= 1'b0;
            s1_any   <= 1'b0;
            s1_func  <= '0;
            s1_wsel  <= '0;
            s1_lo    <= '0;
            s1_hi    <= '0;
            s1_ones  <= '0;
        end else begin
            s1_valid <= in_valid;
            s1_any   <= any_c;
            s1_func  <= in_func;
            s1_wsel  <= in_width;
            s1_lo    <= lo_c;
            s1_hi    <= hi_c;
            s1_ones  <= ones_c;
        end
    end

    logic [RW-1:0] width_val, pick;
    logic          hold;

    // Width as a count value for the zero-count rules.
    always_comb begin
        unique case (s1_wsel)
            WSEL_16: width_val = RW'(W_Q);
            WSEL_32: width_val = RW'(W_H);
            default: width_val = RW'(DATA_W);
        endcase
    end

    // Select the requested answer and the zero-operand convention.
    always_comb begin
        hold = 1'b0;
        unique case (s1_func)
            FN_LOW_IDX: begin
                pick = RW'(s1_lo);
                hold = !s1_any;
            end
            FN_HIGH_IDX: begin
                pick = RW'(s1_hi);
                hold = !s1_any;
            end
            FN_LEAD_Z:  pick = s1_any ? (width_val - RW'(1) - RW'(s1_hi)) : width_val;
            FN_TRAIL_Z: pick = s1_any ? RW'(s1_lo) : width_val;
            default:    pick = s1_ones;
        endcase
    end

    // Stage 2 register: result, flag and valid.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            out_valid  <= 1'b0;
            out_result <= '0;
            out_zero   <= 1'b0;
        end else begin
            out_valid <= s1_valid;
            if (s1_valid) begin
                out_zero <= !s1_any;
                if (!hold) out_result <= pick;
            end
        end
    end

    logic unused_ok;
    assign unused_ok = any_hi_unused;
endmodule

// File: rtl/bsc_unit_chk.sv
// Checker for bsc_unit: relates each result to the request two cycles back.
// Assumes: in_valid low while rst_n is low.
module bsc_unit_chk #(
    parameter int DATA_W = 64,
    localparam int RW    = $clog2(DATA_W) + 1
) (
    input logic              clk,
    input logic              rst_n,
    input logic              in_valid,
    input logic [DATA_W-1:0] in_data,
    input logic [2:0]        in_func,
    input logic [1:0]        in_width,
    input logic              out_valid,
    input logic [RW-1:0]     out_result,
    input logic              out_zero
);
    logic [1:0]    seen;
    logic          op_zero;
    logic [RW-1:0] wval;

    // Count cycles since reset, saturating, to arm the two-cycle checks.
    always_ff @(posedge clk) begin
        if (!rst_n) seen <= '0;
        else if (seen != 2'd3) seen <= seen + 2'd1;
    end

    // Independent view of the operand width and zero operand.
    always_comb begin
        case (in_width)
            2'd0: begin
                wval = RW'(DATA_W / 4);
                op_zero = (in_data & ((64'd1 << (DATA_W / 4)) - 64'd1)) == '0;
            end
            2'd1: begin
                wval = RW'(DATA_W / 2);
                op_zero = (in_data & ((64'd1 << (DATA_W / 2)) - 64'd1)) == '0;
            end
            default: begin
                wval = RW'(DATA_W);
                op_zero = in_data == '0;
            end
        endcase
    end

    AST_LATENCY: assert property (@(posedge clk) disable iff (!rst_n)
        (seen >= 2'd2) |-> (out_valid == $past(in_valid, 2)));  // R10
    AST_ZERO_FLAG: assert property (@(posedge clk) disable iff (!rst_n)
        (seen >= 2'd2) && $past(in_valid, 2) |-> (out_zero == $past(op_zero, 2)));  // R7
    AST_SCAN_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        (seen >= 2'd2) && $past(in_valid && op_zero && (in_func <= 3'd1), 2)
        |-> $stable(out_result));  // R8
    AST_COUNT_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
        (seen >= 2'd2) && $past(in_valid && op_zero && (in_func == 3'd2 || in_func == 3'd3), 2)
        |-> (out_result == $past(wval, 2)));  // R9
    AST_ONES_NONZERO: assert property (@(posedge clk) disable iff (!rst_n)
        (seen >= 2'd2) && $past(in_valid && !op_zero && (in_func >= 3'd4), 2)
        |-> (out_result != '0));  // R5
    AST_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
        out_valid |-> (out_result <= RW'(DATA_W)));  // R6
    AST_IDLE_STABLE: assert property (@(posedge clk) disable iff (!rst_n)
        (seen >= 2'd2) && !$past(in_valid, 2) |-> $stable(out_result));  // R8
endmodule

bind bsc_unit bsc_unit_chk #(.DATA_W(DATA_W)) u_chk (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_data(in_data),
    .in_func(in_func), .in_width(in_width), .out_valid(out_valid),
    .out_result(out_result), .out_zero(out_zero));

// File: tb/bsc_unit_tb.sv
module bsc_unit_tb;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        in_valid = 1'b0;
    logic [63:0] in_data = '0;
    logic [2:0]  in_func = '0;
    logic [1:0]  in_width = '0;
    logic        out_valid;
    logic [6:0]  out_result;
    logic        out_zero;

    int checks = 0;
    int fails  = 0;
    bit done   = 0;

    // Model pipeline: index 0 is last driven, index 1 is due now.
    bit         pv [2];
    logic [6:0] pres [2];
    bit         pz [2];
    string      ptag [2];
    logic [6:0] held = '0;

    always #5 clk = ~clk;

    bsc_unit u_dut (
        .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_data(in_data),
        .in_func(in_func), .in_width(in_width), .out_valid(out_valid),
        .out_result(out_result), .out_zero(out_zero));

    function automatic int wbits(input logic [1:0] w);
        return (w == 2'd0) ? 16 : (w == 2'd1) ? 32 : 64;
    endfunction

    function automatic logic [63:0] narrow(input logic [63:0] d, input logic [1:0] w);
        logic [63:0] r = '0;
        for (int i = 0; i < wbits(w); i++) r[i] = d[i];
        return r;
    endfunction

    function automatic int low_idx(input logic [63:0] d);
        for (int i = 0; i < 64; i++) if (d[i]) return i;
        return -1;
    endfunction

    function automatic int high_idx(input logic [63:0] d);
        for (int i = 63; i >= 0; i--) if (d[i]) return i;
        return -1;
    endfunction

    function automatic int ones(input logic [63:0] d);
        int n = 0;
        for (int i = 0; i < 64; i++) n += int'(d[i]);
        return n;
    endfunction

    task automatic check(input bit ok, input string tag, input int act, input int exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
        end
    endtask

    // Compare outputs against the entry due now, then shift in the new one.
    task automatic step(input bit v, input logic [63:0] d, input logic [2:0] f,
                        input logic [1:0] w, input string tag);
        logic [63:0] n;
        int w_b, r;
        bit z, scan;
        @(negedge clk);
        check(out_valid == pv[1], "R10 valid", int'(out_valid), int'(pv[1]));
        if (pv[1]) begin
            check(out_zero == pz[1], {"R7 flag ", ptag[1]}, int'(out_zero), int'(pz[1]));
            check(out_result == pres[1], ptag[1], int'(out_result), int'(pres[1]));
        end
        n = narrow(d, w);
        w_b = wbits(w);
        z = (n == '0);
        scan = (f <= 3'd1);
        r = int'(held);
        if (v) begin
            if (!(z && scan)) begin
                case (f)
                    3'd0: r = low_idx(n);
                    3'd1: r = high_idx(n);
                    3'd2: r = z ? w_b : (w_b - 1 - high_idx(n));
                    3'd3: r = z ? w_b : low_idx(n);
                    default: r = ones(n);
                endcase
            end
            held = 7'(r);
        end
        pv[1] = pv[0];  pres[1] = pres[0];  pz[1] = pz[0];  ptag[1] = ptag[0];
        pv[0] = v;      pres[0] = held;     pz[0] = z;
        if (tag != "") ptag[0] = tag;
        else if (z && scan) ptag[0] = "R8 scan hold";
        else if (z && (f == 3'd2 || f == 3'd3)) ptag[0] = "R9 zero count";
        else begin
            case (f)
                3'd0: ptag[0] = "R1 low index";
                3'd1: ptag[0] = "R2 high index";
                3'd2: ptag[0] = "R3 leading zeros";
                3'd3: ptag[0] = "R4 trailing zeros";
                default: ptag[0] = "R5 ones";
            endcase
        end
        in_valid = v;
        in_data  = d;
        in_func  = f;
        in_width = w;
    endtask

    initial begin : watchdog
        #(200000 * 10);
        if (!done) begin
            fails++;
            checks++;
            $display("FAIL watchdog actual=1 expected=0");
            $display("%0d/%0d checks passed", checks - fails, checks);
            $finish;
        end
    end

    initial begin : main
        int seed;
        seed = 17;
        void'($urandom(seed));
        for (int i = 0; i < 2; i++) begin
            pv[i] = 0; pres[i] = '0; pz[i] = 0; ptag[i] = "";
        end
        repeat (3) @(negedge clk);
        // R11: reset clears all outputs.
        check(out_valid == 1'b0, "R11 reset valid", int'(out_valid), 0);
        check(out_result == '0, "R11 reset result", int'(out_result), 0);
        check(out_zero == 1'b0, "R11 reset zero", int'(out_zero), 0);
        rst_n = 1'b1;

        // Directed corners.
        step(1, 64'h18, 3'd0, 2'd1, "R1 low index 0x18");
        step(1, 64'h18, 3'd1, 2'd1, "R2 high index 0x18");
        step(1, 64'hA0, 3'd2, 2'd1, "R3 leading zeros 0xA0 at 32");
        step(1, 64'hA0, 3'd2, 2'd0, "R3 leading zeros 0xA0 at 16");
        step(1, 64'hA0, 3'd3, 2'd2, "R4 trailing zeros 0xA0");
        step(1, 64'hB5, 3'd4, 2'd0, "R5 ones 0xB5");
        step(1, 64'hB5, 3'd7, 2'd0, "R5 ones code 7");
        step(1, 64'hFFFF_0000, 3'd1, 2'd0, "R6 R8 upper bits ignored scan hold");
        step(1, 64'h0, 3'd0, 2'd2, "R8 low scan zero hold");
        step(0, 64'h5, 3'd4, 2'd0, "");
        step(1, 64'hFFFF_FFFF_0000_0000, 3'd2, 2'd1, "R6 R9 leading zeros 32 zero");
        step(1, 64'h0, 3'd3, 2'd0, "R9 trailing zeros 16 zero");
        step(1, 64'h0, 3'd2, 2'd3, "R6 R9 width code 3 is 64");
        step(1, 64'h8000_0000_0000_0000, 3'd1, 2'd2, "R2 top bit 64");
        step(1, 64'hFFFF_FFFF_FFFF_FFFF, 3'd4, 2'd2, "R5 all ones 64");
        step(1, 64'h1_0000, 3'd4, 2'd0, "R6 R7 ones ignored upper");

        // Random traffic with frequent zero and single-bit operands.
        for (int k = 0; k < 4000; k++) begin
            logic [63:0] d;
            int kind;
            kind = int'($urandom_range(0, 3));
            case (kind)
                0: d = '0;
                1: d = 64'd1 << $urandom_range(0, 63);
                2: d = {32'($urandom), 32'd0};
                default: d = {32'($urandom), 32'($urandom)};
            endcase
            step(bit'($urandom_range(0, 3) != 0), d, 3'($urandom_range(0, 7)),
                 2'($urandom_range(0, 3)), "");
        end
        step(0, '0, '0, '0, "");
        step(0, '0, '0, '0, "");
        step(0, '0, '0, '0, "");
        done = 1;
        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    end
endmodule